// File: doc/BRIEF.md
# Write Unlock Sequencer

This block stands in front of the page-load stage of a parallel nonvolatile memory. It lets a write reach the load stage only after the host has issued a fixed three-step command sequence. The block watches the bus control levels (chip enable, output enable, write enable) and detects each falling edge of write enable that arrives while the chip is selected and output enable is high. It compares the address and data of that write against the expected command step. The three command writes do not pass to the load stage. After the third step, each later write is granted to the load stage as a one-cycle accept pulse. Protection returns on its own when the programming cycle completes.

A write that arrives while the block is protected and does not match the expected step is flagged with a one-cycle `badWrite` pulse. The downstream programming timer uses this pulse to start a busy period in which no data is stored. The gap between successive writes has a limit in clock cycles. If a partial sequence goes stale, the sequencer falls back to its first step. A load window that ends with no byte accepted simply re-locks. A load window that ends after bytes were accepted closes and waits for the end of programming. After reset, every write is ignored until a parameterised power-up delay has elapsed.

Top module: `write_unlock_seq`

## Requirements
- R1: While reset is asserted and just after it, `loadAccept`, `badWrite` and `unlocked` are all 0.
- R2: During the first `PWRUP_CYCLES` cycles after reset release, write strobes are ignored: no pulse on either output, and the sequencer does not advance.
- R3: A write is recognised only on a high-to-low transition of `wrEnN` while `chipEnN` is 0 and `outEnN` is 1. A strobe seen with chip enable high or output enable low has no effect on the outputs or on the sequence step.
- R4: The command steps, in order, are data 0xAA at address 0x1555, then data 0x55 at address 0x0AAA, then data 0xA0 at address 0x1555. None of them produces `loadAccept` or `badWrite`. `unlocked` rises one cycle after the strobe of the third step.
- R5: While `unlocked` is 1, every recognised write produces exactly one `loadAccept` pulse, one cycle after its strobe edge. This holds for the command addresses too.
- R6: A write with wrong address or data at the second or third command step produces a `badWrite` pulse, and the sequencer returns to the first step.
- R7: A write while at the first step that is not the first command produces a `badWrite` pulse.
- R8: If more than `BLC_CYCLES` cycles pass after a command step without the next write, the sequencer silently returns to the first step. A write inside the limit continues the sequence.
- R9: A `progDone` pulse while unlocked or closed returns the block to the protected first step. The next data write is then flagged as bad.
- R10: If the load window expires with no byte accepted, the block re-locks to the first step.
- R11: If the load window expires after at least one byte was accepted, `unlocked` falls and later writes are ignored (no pulses) until `progDone`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; also marks power-up |
| chipEnN | input | 1 | Chip enable level, active low |
| outEnN | input | 1 | Output enable level, active low |
| wrEnN | input | 1 | Write enable level, active low |
| addr | input | ADDR_W | Bus address |
| data | input | DATA_W | Bus write data |
| progDone | input | 1 | One-cycle pulse at the end of a programming cycle |
| loadAccept | output | 1 | One-cycle grant of a data write to the load stage |
| badWrite | output | 1 | One-cycle flag for a write that failed the sequence |
| unlocked | output | 1 | High while the load window is open |

## Verification
The bench targets a wrong value at the second and at the third step. A sequencer that forgot to fall back would unlock on the next good command, or stay silent instead of flagging. Inhibited strobes and strobes inside the power-up delay are followed by a probe write, which exposes a design that counted them as a step. The timeout is probed on both sides of the limit. Both ends of the load window are covered: an empty window must re-lock, and a filled one must swallow further writes until programming completes. A design that confused these would emit a stray accept or bad pulse.

// File: rtl/wp_pkg.sv
package wp_pkg;

  localparam logic [12:0] CMD_ADDR_A = 13'h1555;
  localparam logic [12:0] CMD_ADDR_B = 13'h0AAA;
  localparam logic [7:0]  CMD_DATA_1 = 8'hAA;
  localparam logic [7:0]  CMD_DATA_2 = 8'h55;
  localparam logic [7:0]  CMD_DATA_3 = 8'hA0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STEP1,
    ST_STEP2,
    ST_OPEN,
    ST_CLOSED
  } seqState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic timerClr;
    logic timerRun;
  } dpCtl_t;

  // datapath -> control status
  typedef struct packed {
    logic wrEvt;
    logic hit1;
    logic hit2;
    logic hit3;
    logic blcExpired;
    logic armed;
  } dpStat_t;

endpackage

// File: rtl/wp_datapath.sv
module wp_datapath
  import wp_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int DATA_W       = 8,
  parameter int PWRUP_CYCLES = 1250000,
  parameter int BLC_CYCLES   = 12500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic              outEnN,
  input  logic              wrEnN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  dpCtl_t            ctl,
  output dpStat_t           stat
);

  localparam int PU_W  = $clog2(PWRUP_CYCLES + 1);
  localparam int BLC_W = $clog2(BLC_CYCLES + 1);
  localparam logic [PU_W-1:0]  PU_LAST  = PU_W'(PWRUP_CYCLES);
  localparam logic [BLC_W-1:0] BLC_LAST = BLC_W'(BLC_CYCLES);

  logic             prevWe;
  logic [PU_W-1:0]  puCnt;
  logic [BLC_W-1:0] blcCnt;
  logic             isAddrA, isAddrB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevWe <= 1'b1;
      puCnt  <= '0;
      blcCnt <= BLC_LAST;
    end else begin
      prevWe <= wrEnN;
      if (puCnt != PU_LAST) puCnt <= puCnt + 1'b1;
      if (ctl.timerClr)                          blcCnt <= '0;
      else if (ctl.timerRun && blcCnt != BLC_LAST) blcCnt <= blcCnt + 1'b1;
    end
  end

  assign isAddrA = (addr == ADDR_W'(CMD_ADDR_A));
  assign isAddrB = (addr == ADDR_W'(CMD_ADDR_B));

  always_comb begin
    stat.armed      = (puCnt == PU_LAST);
    stat.wrEvt      = prevWe && !wrEnN && !chipEnN && outEnN && stat.armed;
    stat.hit1       = isAddrA && (data == DATA_W'(CMD_DATA_1));
    stat.hit2       = isAddrB && (data == DATA_W'(CMD_DATA_2));
    stat.hit3       = isAddrA && (data == DATA_W'(CMD_DATA_3));
    stat.blcExpired = ctl.timerRun && (blcCnt == BLC_LAST);
  end

  // a recognised strobe needs write enable to go high again first
  p_edge_r3: assert property (@(posedge clk) disable iff (!rstN)
    stat.wrEvt |=> !stat.wrEvt);

  // the gap counter saturates at its limit
  p_blc_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (blcCnt == BLC_LAST && !ctl.timerClr) |=> (blcCnt == BLC_LAST));

endmodule

// File: rtl/wp_control.sv
module wp_control
  import wp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    progDone,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    loadAccept,
  output logic    badWrite,
  output logic    unlocked
);

  seqState_e state, nxtState;
  logic      gotByte;
  logic      accNxt, badNxt;

  always_comb begin
    nxtState     = state;
    accNxt       = 1'b0;
    badNxt       = 1'b0;
    ctl.timerClr = 1'b0;
    ctl.timerRun = (state == ST_STEP1) || (state == ST_STEP2) || (state == ST_OPEN);
    unique case (state)
      ST_IDLE: begin
        if (stat.wrEvt) begin
          if (stat.hit1) begin
            nxtState     = ST_STEP1;
            ctl.timerClr = 1'b1;
          end else begin
            badNxt = 1'b1;
          end
        end
      end
      ST_STEP1: begin
        if (stat.wrEvt) begin
          if (stat.hit2) begin
            nxtState     = ST_STEP2;
            ctl.timerClr = 1'b1;
          end else begin
            nxtState = ST_IDLE;
            badNxt   = 1'b1;
          end
        end else if (stat.blcExpired) begin
          nxtState = ST_IDLE;
        end
      end
      ST_STEP2: begin
        if (stat.wrEvt) begin
          if (stat.hit3) begin
            nxtState     = ST_OPEN;
            ctl.timerClr = 1'b1;
          end else begin
            nxtState = ST_IDLE;
            badNxt   = 1'b1;
          end
        end else if (stat.blcExpired) begin
          nxtState = ST_IDLE;
        end
      end
      ST_OPEN: begin
        if (progDone) begin
          nxtState = ST_IDLE;
        end else if (stat.wrEvt) begin
          accNxt       = 1'b1;
          ctl.timerClr = 1'b1;
        end else if (stat.blcExpired) begin
          nxtState = gotByte ? ST_CLOSED : ST_IDLE;
        end
      end
      ST_CLOSED: begin
        if (progDone) nxtState = ST_IDLE;
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      gotByte    <= 1'b0;
      loadAccept <= 1'b0;
      badWrite   <= 1'b0;
    end else begin
      state      <= nxtState;
      gotByte    <= (nxtState == ST_OPEN) && (gotByte || accNxt);
      loadAccept <= accNxt;
      badWrite   <= badNxt;
    end
  end

  assign unlocked = (state == ST_OPEN);

  // entering the open window is silent on both pulse outputs
  p_silent_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> (!loadAccept && !badWrite));

  p_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    loadAccept |=> !loadAccept);

  p_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(loadAccept && badWrite));

  p_lockout_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stat.armed |=> (!loadAccept && !badWrite));

  p_closed_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CLOSED && $past(state) == ST_CLOSED) |-> (!loadAccept && !badWrite));

endmodule

// File: rtl/write_unlock_seq.sv
module write_unlock_seq
  import wp_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int DATA_W       = 8,
  parameter int PWRUP_CYCLES = 1250000,
  parameter int BLC_CYCLES   = 12500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic              outEnN,
  input  logic              wrEnN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              progDone,
  output logic              loadAccept,
  output logic              badWrite,
  output logic              unlocked
);

  dpCtl_t  dpCtl;
  dpStat_t dpStat;

  wp_datapath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .PWRUP_CYCLES(PWRUP_CYCLES),
    .BLC_CYCLES  (BLC_CYCLES)
  ) i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .chipEnN(chipEnN),
    .outEnN (outEnN),
    .wrEnN  (wrEnN),
    .addr   (addr),
    .data   (data),
    .ctl    (dpCtl),
    .stat   (dpStat)
  );

  wp_control i_control (
    .clk       (clk),
    .rstN      (rstN),
    .progDone  (progDone),
    .stat      (dpStat),
    .ctl       (dpCtl),
    .loadAccept(loadAccept),
    .badWrite  (badWrite),
    .unlocked  (unlocked)
  );

endmodule

// File: tb/test_write_unlock_seq.sv
module test_write_unlock_seq;

  localparam int PU  = 50;
  localparam int BLC = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chipEnN = 1'b0;
  logic        outEnN = 1'b1;
  logic        wrEnN = 1'b1;
  logic [12:0] addr = '0;
  logic [7:0]  data = '0;
  logic        progDone = 1'b0;
  logic        loadAccept, badWrite, unlocked;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit    acc;
    bit    bad;
    bit    unl;
    string tag;
  } exp_t;

  exp_t expQ[$];
  event sampleEv;

  always #4 clk = ~clk;

  write_unlock_seq #(
    .ADDR_W(13), .DATA_W(8), .PWRUP_CYCLES(PU), .BLC_CYCLES(BLC)
  ) i_write_unlock_seq (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .outEnN(outEnN), .wrEnN(wrEnN),
    .addr(addr), .data(data), .progDone(progDone),
    .loadAccept(loadAccept), .badWrite(badWrite), .unlocked(unlocked)
  );

  // monitor: pops one expected item per write and compares
  always @(sampleEv) begin
    exp_t e;
    e = expQ.pop_front();
    checks++;
    if (loadAccept !== e.acc || badWrite !== e.bad || unlocked !== e.unl) begin
      errors++;
      $display("FAIL %s: acc/bad/unl = %b%b%b expected %b%b%b",
               e.tag, loadAccept, badWrite, unlocked, e.acc, e.bad, e.unl);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // driver: one write strobe, expected result queued for the monitor
  task automatic doWrite(input logic [12:0] a, input logic [7:0] d,
                         input bit acc, input bit bad, input bit unl, input string tag);
    exp_t e;
    @(negedge clk);
    addr = a; data = d; wrEnN = 1'b0;
    e.acc = acc; e.bad = bad; e.unl = unl; e.tag = tag;
    expQ.push_back(e);
    @(posedge clk);
    @(negedge clk);
    ->sampleEv;
    #1;
    wrEnN = 1'b1;
    @(negedge clk);
  endtask

  task automatic checkUnl(input bit exp, input string tag);
    checks++;
    if (unlocked !== exp) begin
      errors++;
      $display("FAIL %s: unlocked = %b expected %b", tag, unlocked, exp);
    end
  endtask

  task automatic pulseDone();
    @(negedge clk); progDone = 1'b1;
    @(negedge clk); progDone = 1'b0;
  endtask

  task automatic unlockSeq(input string tag);
    doWrite(13'h1555, 8'hAA, 0, 0, 0, tag);
    doWrite(13'h0AAA, 8'h55, 0, 0, 0, tag);
    doWrite(13'h1555, 8'hA0, 0, 0, 1, tag);
  endtask

  initial begin
    idle(3);
    checks++;
    if (loadAccept !== 1'b0 || badWrite !== 1'b0 || unlocked !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset outputs %b%b%b expected 000", loadAccept, badWrite, unlocked);
    end
    rstN = 1'b1;
    idle(2);
    checks++;
    if (loadAccept !== 1'b0 || badWrite !== 1'b0 || unlocked !== 1'b0) begin
      errors++;
      $display("FAIL R1: post-reset outputs %b%b%b expected 000", loadAccept, badWrite, unlocked);
    end

    // R2: strobes inside the power-up delay are ignored
    doWrite(13'h1555, 8'hAA, 0, 0, 0, "R2 lockout cmd");
    doWrite(13'h0123, 8'h77, 0, 0, 0, "R2 lockout junk");
    idle(PU + 10);
    // R2: first step was not taken, so this second-step write is bad
    doWrite(13'h0AAA, 8'h55, 0, 1, 0, "R2 no advance");

    // R3: inhibited strobes
    chipEnN = 1'b1;
    doWrite(13'h1555, 8'hAA, 0, 0, 0, "R3 chip disabled");
    chipEnN = 1'b0; outEnN = 1'b0;
    doWrite(13'h0777, 8'h12, 0, 0, 0, "R3 output enabled");
    outEnN = 1'b1;
    doWrite(13'h0AAA, 8'h55, 0, 1, 0, "R3 no advance");

    // R7: unauthorized write while protected
    doWrite(13'h0123, 8'h5A, 0, 1, 0, "R7 bad write");

    // R4 / R5: sequence then data, including command addresses
    unlockSeq("R4 sequence");
    doWrite(13'h0040, 8'h11, 1, 0, 1, "R5 data");
    doWrite(13'h1555, 8'hAA, 1, 0, 1, "R5 cmd address as data");

    // R9: end of programming re-locks
    pulseDone();
    checkUnl(0, "R9 relock");
    doWrite(13'h0040, 8'h11, 0, 1, 0, "R9 needs sequence");

    // R6: wrong second and third steps
    doWrite(13'h1555, 8'hAA, 0, 0, 0, "R6 step1");
    doWrite(13'h1555, 8'h55, 0, 1, 0, "R6 wrong step2 addr");
    doWrite(13'h1555, 8'hA0, 0, 1, 0, "R6 back at first step");
    doWrite(13'h1555, 8'hAA, 0, 0, 0, "R6 step1");
    doWrite(13'h0AAA, 8'h55, 0, 0, 0, "R6 step2");
    doWrite(13'h1555, 8'hA5, 0, 1, 0, "R6 wrong step3 data");
    unlockSeq("R6 recover");
    pulseDone();

    // R8: timeout between commands
    doWrite(13'h1555, 8'hAA, 0, 0, 0, "R8 step1");
    idle(BLC + 20);
    doWrite(13'h0AAA, 8'h55, 0, 1, 0, "R8 timed out");
    doWrite(13'h1555, 8'hAA, 0, 0, 0, "R8 step1 in window");
    idle(10);
    doWrite(13'h0AAA, 8'h55, 0, 0, 0, "R8 step2 in window");
    idle(10);
    doWrite(13'h1555, 8'hA0, 0, 0, 1, "R8 step3 in window");
    pulseDone();

    // R10: empty window expires
    unlockSeq("R10 sequence");
    idle(BLC + 20);
    checkUnl(0, "R10 empty window relock");
    doWrite(13'h0040, 8'h22, 0, 1, 0, "R10 locked again");

    // R11: window with bytes expires, closes until progDone
    unlockSeq("R11 sequence");
    doWrite(13'h0080, 8'h33, 1, 0, 1, "R11 data");
    idle(BLC + 20);
    checkUnl(0, "R11 closed");
    doWrite(13'h0081, 8'h44, 0, 0, 0, "R11 ignored while closed");
    doWrite(13'h0123, 8'h00, 0, 0, 0, "R11 ignored while closed");
    pulseDone();
    doWrite(13'h0081, 8'h44, 0, 1, 0, "R11 relocked after done");

    idle(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule